// File: doc/BRIEF.md
# Staged Module Power-State Controller

This block holds the clock and reset state of a group of peripheral modules. Software does not change a module's state directly. It first writes a requested state into that module's control register. The request has no effect on the outputs until software writes a start command. After the command, every module whose requested state differs from its present state moves together. The move takes a fixed settling time. During that time a busy flag is set, and at the end each module's status register reads back its new state.

The modules are split across two independent controller domains. Module identifiers below a fixed base belong to the first domain. Identifiers from the base upward belong to the second domain, and the base is subtracted to give the local index. Each domain has its own start command and its own busy flag.

The register bus is a simple synchronous write port with a combinational read port. The address is formed as `{kind[1:0], id[5:0]}`, where kind 0 selects a control register, kind 1 a status register, kind 2 a domain command and kind 3 a domain busy flag. For kinds 2 and 3, address bit 0 picks the domain (0 for the first, 1 for the second).

Top module: `msc_top`

## Requirements
- R1: After reset every module is disabled: all `mod_clk_en` and `mod_rst_rel` bits are 0, both busy flags read 0, and every control register reads 0.
- R2: State code 0 (disabled) drives clock enable 0 and reset release 0. Code 1 (synchronous reset) drives clock enable 1 and reset release 0. Code 3 (enabled) drives both to 1. Reset release is never high while clock enable is low.
- R3: A control register (kind 0) stores and reads back the whole 8-bit write. Only bits [1:0] form the requested state. A control write alone leaves the outputs and the status unchanged.
- R4: Writing 1 in data bit 0 to a domain command (kind 2) while that domain is idle, with at least one module differing, sets its busy flag (kind 3, bit 0) from the next cycle for exactly 4 cycles. On the cycle the flag clears, the moved modules' outputs and status fields (kind 1, bits [1:0]) take the requested state.
- R5: A command write with data bit 0 at 0 has no effect.
- R6: A command written while the domain is busy is ignored and does not lengthen the busy period.
- R7: A command issued when no module of the domain differs from its requested state leaves the busy flag at 0 and the outputs unchanged.
- R8: Requested code 2 is treated as disabled. A module requested with code 2 ends with status 0 and both outputs low.
- R9: Identifiers that map to no module (4 to 31 and 35 to 63 with the default parameters) ignore writes and read as 0.
- R10: Identifier 32+j addresses module j of the second domain, which drives output bit 4+j. A command to one domain never moves the modules of the other.
- R11: The requested state is captured when the command is accepted. Control writes made during the busy period do not alter the transition in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address {kind, id} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| mod_clk_en | output | 7 | Per-module clock enable (first domain in low bits) |
| mod_rst_rel | output | 7 | Per-module reset release |

## Verification
The bench counts the busy window cycle by cycle. A counter that is off by one, or that restarts on a second command, shows up as a busy flag at the wrong sample. It writes a new request in the middle of a transition. A design that reads the control register at completion instead of at the command would then land in the wrong state. It also sends the reserved code, unmapped identifiers and identifiers just below and just past the second base. A design that decoded these loosely would switch a module on, or would alias into a real register whose readback or outputs then change. Finally, it issues commands with nothing pending and commands aimed at the other domain. Here a design that set busy anyway, or that shared one start line between the domains, would be caught.

// File: rtl/msc_pkg.sv
// Package: shared module-state encoding for the staged power-state controller.
// Assumes a 2-bit state code where 2 is reserved and never held as a state.
package msc_pkg;

    typedef enum logic [1:0] {
        MS_OFF  = 2'd0,
        MS_SRST = 2'd1,
        MS_RSVD = 2'd2,
        MS_ON   = 2'd3
    } mstate_t;

    // Fold a requested code onto a legal state (reserved becomes disabled).
    function automatic mstate_t resolve_state(input logic [1:0] code);
        return (code == 2'd2) ? MS_OFF : mstate_t'(code);
    endfunction

endpackage

// File: rtl/msc_slot.sv
// Module: one controlled peripheral slot.
// Holds the software control byte, the state captured at launch and the
// present state, and decodes the present state into clock/reset outputs.
// Assumes launch and done never arrive in the same cycle.
module msc_slot
    import msc_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              launch,
    input  logic              done,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [1:0]        cur_q,
    output logic              pending,
    output logic              clk_en,
    output logic              rst_rel
);

    mstate_t want;
    mstate_t tgt;
    mstate_t cur;

    // Control byte: keeps every bit software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Capture the target at launch, commit it when the domain finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= MS_OFF;
            cur <= MS_OFF;
        end else begin
            if (launch) tgt <= want;
            if (done)   cur <= tgt;
        end
    end

    // Requested state and output decode of the present state.
    always_comb begin
        want    = resolve_state(ctrl_q[1:0]);
        pending = (want != cur);
        cur_q   = cur;
        clk_en  = (cur == MS_ON) || (cur == MS_SRST);
        rst_rel = (cur == MS_ON);
    end

    assert_legal_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur != MS_RSVD);

    assert_rst_needs_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rel |-> clk_en);

    assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(cur_q));

endmodule

// File: rtl/msc_domain.sv
// Module: one controller domain of N slots sharing a start command,
// a settling counter and a busy flag.
// Assumes TRANS_CYC >= 1; a start request while busy is dropped.
module msc_domain #(
    parameter int N         = 4,
    parameter int CTRL_W    = 8,
    parameter int TRANS_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             ctrl_we,
    input  logic [CTRL_W-1:0]        wdata,
    input  logic                     go_req,
    output logic                     busy,
    output logic [N-1:0][CTRL_W-1:0] ctrl_q,
    output logic [N-1:0][1:0]        cur_q,
    output logic [N-1:0]             clk_en,
    output logic [N-1:0]             rst_rel
);

    localparam int CNT_W = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;

    logic [CNT_W-1:0] cnt;
    logic [N-1:0]     pending;
    logic             launch;
    logic             done;

    // Start only when idle and some slot differs; finish at counter zero.
    always_comb begin
        launch = go_req && !busy && (|pending);
        done   = busy && (cnt == '0);
    end

    // Settling counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(TRANS_CYC - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        msc_slot #(.CTRL_W(CTRL_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[i]),
            .wdata   (wdata),
            .launch  (launch),
            .done    (done),
            .ctrl_q  (ctrl_q[i]),
            .cur_q   (cur_q[i]),
            .pending (pending[i]),
            .clk_en  (clk_en[i]),
            .rst_rel (rst_rel[i])
        );
    end

    assert_busy_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);

    assert_go_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_idle_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go_req && !(|pending)) |=> !busy);

endmodule

// File: rtl/msc_top.sv
// Module: staged module power-state controller, two domains behind one
// register port. Address = {kind[1:0], id}; kind 0 control, 1 status,
// 2 command, 3 busy; for kinds 2/3 address bit 0 picks the domain.
// Assumes N0 <= ID_BASE and ID_BASE + N1 <= 2**ID_W.
module msc_top #(
    parameter int N0        = 4,
    parameter int N1        = 3,
    parameter int ID_W      = 6,
    parameter int ID_BASE   = 32,
    parameter int CTRL_W    = 8,
    parameter int TRANS_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [ID_W+1:0]        bus_addr,
    input  logic [CTRL_W-1:0]      bus_wdata,
    output logic [CTRL_W-1:0]      bus_rdata,
    output logic [N0+N1-1:0]       mod_clk_en,
    output logic [N0+N1-1:0]       mod_rst_rel
);

    localparam int ADDR_W = ID_W + 2;

    logic [1:0]                       kind;
    logic [ID_W-1:0]                  id;
    logic [N0-1:0]                    we0;
    logic [N1-1:0]                    we1;
    logic                             go0, go1, busy0, busy1;
    logic [N0-1:0][CTRL_W-1:0]        ctrl0;
    logic [N1-1:0][CTRL_W-1:0]        ctrl1;
    logic [N0-1:0][1:0]               cur0;
    logic [N1-1:0][1:0]               cur1;

    // Address split and per-slot / per-domain write decode.
    always_comb begin
        kind = bus_addr[ADDR_W-1 -: 2];
        id   = bus_addr[ID_W-1:0];
        for (int i = 0; i < N0; i++)
            we0[i] = bus_we && (kind == 2'd0) && (id == ID_W'(i));
        for (int j = 0; j < N1; j++)
            we1[j] = bus_we && (kind == 2'd0) && (id == ID_W'(ID_BASE + j));
        go0 = bus_we && (kind == 2'd2) && !bus_addr[0] && bus_wdata[0];
        go1 = bus_we && (kind == 2'd2) &&  bus_addr[0] && bus_wdata[0];
    end

    msc_domain #(.N(N0), .CTRL_W(CTRL_W), .TRANS_CYC(TRANS_CYC)) u_dom0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (we0),
        .wdata   (bus_wdata),
        .go_req  (go0),
        .busy    (busy0),
        .ctrl_q  (ctrl0),
        .cur_q   (cur0),
        .clk_en  (mod_clk_en[N0-1:0]),
        .rst_rel (mod_rst_rel[N0-1:0])
    );

    msc_domain #(.N(N1), .CTRL_W(CTRL_W), .TRANS_CYC(TRANS_CYC)) u_dom1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (we1),
        .wdata   (bus_wdata),
        .go_req  (go1),
        .busy    (busy1),
        .ctrl_q  (ctrl1),
        .cur_q   (cur1),
        .clk_en  (mod_clk_en[N0+N1-1:N0]),
        .rst_rel (mod_rst_rel[N0+N1-1:N0])
    );

    // Read multiplexer; unmapped identifiers and commands read as zero.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            2'd0: begin
                for (int i = 0; i < N0; i++)
                    if (id == ID_W'(i)) bus_rdata = ctrl0[i];
                for (int j = 0; j < N1; j++)
                    if (id == ID_W'(ID_BASE + j)) bus_rdata = ctrl1[j];
            end
            2'd1: begin
                for (int i = 0; i < N0; i++)
                    if (id == ID_W'(i)) bus_rdata = CTRL_W'(cur0[i]);
                for (int j = 0; j < N1; j++)
                    if (id == ID_W'(ID_BASE + j)) bus_rdata = CTRL_W'(cur1[j]);
            end
            2'd3:    bus_rdata = CTRL_W'(bus_addr[0] ? busy1 : busy0);
            default: bus_rdata = '0;
        endcase
    end

    assert_domains_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go0 && !busy1) |=> $stable(mod_clk_en[N0+N1-1:N0]));

endmodule

// File: tb/test_msc_top.sv
// Directed bench for msc_top: one task per scenario, each checking itself.
module test_msc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] mod_clk_en;
    logic [6:0] mod_rst_rel;

    int errors = 0;
    int checks = 0;
    logic [6:0] exp_ce = '0;
    logic [6:0] exp_rr = '0;

    always #4 clk = ~clk;

    msc_top i_msc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .mod_clk_en  (mod_clk_en),
        .mod_rst_rel (mod_rst_rel)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One register write; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_outs(input string tag);
        chk(32'(mod_clk_en), 32'(exp_ce), {tag, " clk_en"});
        chk(32'(mod_rst_rel), 32'(exp_rr), {tag, " rst_rel"});
    endtask

    // Command with full busy-window check, then new outputs.
    task automatic go_timed(input bit dom, input logic [6:0] ce, input logic [6:0] rr, input string tag);
        logic [7:0] d;
        wr(8'h80 | 8'(dom), 8'h01);
        for (int c = 0; c < 4; c++) begin
            if (c > 0) @(negedge clk);
            rd(8'hC0 | 8'(dom), d);
            chk(32'(d), 32'h1, {tag, " busy window"});
            chk_outs({tag, " held during busy"});
        end
        @(negedge clk);
        rd(8'hC0 | 8'(dom), d);
        chk(32'(d), 32'h0, {tag, " busy cleared"});
        exp_ce = ce; exp_rr = rr;
        chk_outs({tag, " after transition"});
    endtask

    // Command that must not start anything.
    task automatic go_idle(input bit dom, input logic [7:0] d0, input string tag);
        logic [7:0] d;
        wr(8'h80 | 8'(dom), d0);
        rd(8'hC0 | 8'(dom), d);
        chk(32'(d), 32'h0, {tag, " busy stays low"});
        @(negedge clk);
        rd(8'hC0 | 8'(dom), d);
        chk(32'(d), 32'h0, {tag, " busy stays low later"});
        chk_outs({tag, " outputs unchanged"});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk_outs("R1 reset");
        rd(8'hC0, d); chk(32'(d), 0, "R1 busy dom0");
        rd(8'hC1, d); chk(32'(d), 0, "R1 busy dom1");
        rd(8'h00, d); chk(32'(d), 0, "R1 ctrl id0");
        rd(8'h40, d); chk(32'(d), 0, "R1 status id0");
    endtask

    task automatic t_stage;
        logic [7:0] d;
        wr(8'h00, 8'hA7);
        rd(8'h00, d); chk(32'(d), 32'hA7, "R3 ctrl readback");
        repeat (3) @(negedge clk);
        rd(8'h40, d); chk(32'(d), 0, "R3 status before go");
        chk_outs("R3 staged only");
    endtask

    task automatic t_go_zero;
        go_idle(1'b0, 8'hFE, "R5 command bit0 clear");
    endtask

    task automatic t_enable;
        logic [7:0] d;
        go_timed(1'b0, 7'b0000001, 7'b0000001, "R4 enable id0");
        rd(8'h40, d); chk(32'(d), 3, "R4 status id0");
    endtask

    task automatic t_srst;
        logic [7:0] d;
        wr(8'h01, 8'h01);
        go_timed(1'b0, 7'b0000011, 7'b0000001, "R2 sync reset id1");
        rd(8'h41, d); chk(32'(d), 1, "R2 status id1");
    endtask

    task automatic t_go_busy;
        logic [7:0] d;
        wr(8'h02, 8'h03);
        wr(8'h80, 8'h01);              // accepted at edge k
        rd(8'hC0, d); chk(32'(d), 1, "R6 busy after first go");
        wr(8'h80, 8'h01);              // edge k+2, must be ignored
        rd(8'hC0, d); chk(32'(d), 1, "R6 busy k+2");
        @(negedge clk);
        rd(8'hC0, d); chk(32'(d), 1, "R6 busy k+3");
        @(negedge clk);
        rd(8'hC0, d); chk(32'(d), 0, "R6 busy not extended");
        exp_ce = 7'b0000111; exp_rr = 7'b0000101;
        chk_outs("R6 id2 enabled");
    endtask

    task automatic t_midflight;
        logic [7:0] d;
        wr(8'h00, 8'h00);
        wr(8'h80, 8'h01);
        wr(8'h00, 8'h03);              // during busy: must not alter target
        repeat (3) @(negedge clk);
        rd(8'hC0, d); chk(32'(d), 0, "R11 finished");
        rd(8'h40, d); chk(32'(d), 0, "R11 captured state");
        exp_ce = 7'b0000110; exp_rr = 7'b0000100;
        chk_outs("R11 id0 disabled");
        rd(8'h00, d); chk(32'(d), 3, "R11 ctrl kept late write");
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        wr(8'h02, 8'h02);
        go_timed(1'b0, 7'b0000011, 7'b0000001, "R8 reserved code");
        rd(8'h42, d); chk(32'(d), 0, "R8 status id2 off");
        rd(8'h02, d); chk(32'(d), 2, "R8 ctrl id2 readback");
    endtask

    task automatic t_nopend;
        go_idle(1'b0, 8'h01, "R7 nothing pending");
    endtask

    task automatic t_invalid;
        logic [7:0] d;
        wr(8'h05, 8'h03);
        wr(8'h1F, 8'h03);
        wr(8'h23, 8'h03);
        wr(8'h3F, 8'h03);
        rd(8'h05, d); chk(32'(d), 0, "R9 read id5");
        rd(8'h1F, d); chk(32'(d), 0, "R9 read id31");
        rd(8'h23, d); chk(32'(d), 0, "R9 read id35");
        rd(8'h45, d); chk(32'(d), 0, "R9 status id5");
        go_idle(1'b0, 8'h01, "R9 dom0 untouched");
        go_idle(1'b1, 8'h01, "R9 dom1 untouched");
    endtask

    task automatic t_dom1;
        logic [7:0] d;
        wr(8'h21, 8'h03);
        rd(8'h21, d); chk(32'(d), 3, "R10 ctrl id33");
        rd(8'h01, d); chk(32'(d), 1, "R10 id1 not aliased");
        go_idle(1'b0, 8'h01, "R10 other domain command");
        go_timed(1'b1, 7'b0100011, 7'b0100001, "R10 dom1 enable");
        rd(8'h61, d); chk(32'(d), 3, "R10 status id33");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage();
        t_go_zero();
        t_enable();
        t_srst();
        t_go_busy();
        t_midflight();
        t_reserved();
        t_nopend();
        t_invalid();
        t_dom1();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule